// File: doc/BRIEF.md
# Three-Phase Deadtime Gate Controller

This block sits between a motor-control processor and the gate-drive stages of a three-phase half bridge. Each phase receives two direct commands: a high-side request that is active low and a low-side request that is active high. The block turns these into six registered gate-enable outputs, one high-side and one low-side per phase. Whenever a phase hands over from one switch to the other, the block holds both switches of that phase off for a programmable gap. This deadtime is also what keeps both switches of a leg from conducting at once.

The gap length comes from an 8-bit code that is written through a small parallel configuration port. Each code step is a fixed number of system clock cycles, given by a parameter. Two enable inputs must both be high for any gate to turn on. A fault input overrides everything else and forces every gate off. When the enables drop or the fault is raised, every deadtime counter restarts, so the outputs come back only after a full gap.

Top module: `tpg_deadtime_ctrl`

## Requirements
- R1: For each phase, a low level on `hi_cmd_n[p]` with `lo_cmd[p]` low requests the high-side gate. A high level on `lo_cmd[p]` with `hi_cmd_n[p]` high requests the low-side gate. A gate output only ever rises while its own side is the sole request of that phase.
- R2: When a phase requests both sides at once (`hi_cmd_n[p]`=0 and `lo_cmd[p]`=1), both gate outputs of that phase are low from the next clock edge and stay low while the conflict lasts.
- R3: A gate can be on only while `en_a` and `en_b` are both high. If either is low at a clock edge, all six gates are low after that edge and every deadtime counter restarts. After the enables return, a request is served D cycles later.
- R4: While `fault` is high at a clock edge, all six gate outputs are low after that edge, whatever the other inputs are.
- R5: The high-side and low-side gate outputs of one phase are never high in the same cycle.
- R6: The deadtime is D = (code+1)·STEP_CYC clock cycles; code 0 gives the shortest gap. A newly requested side rises only after both gates of its phase have been low for D consecutive cycles. If the request is held, it rises exactly then, which is D+1 cycles after the request changes over from the opposite side.
- R7: With `cfg_we` high at a clock edge, `cfg_data` becomes the deadtime code. The new code governs the deadtime from the following cycle on.
- R8: While `rst_n` is low at a clock edge (synchronous, active low), all gate outputs are low, all counters restart and the code becomes 255. With the default STEP_CYC of 2, a request that is present when reset is released is served after 512 cycles.
- R9: The three phases are independent. A request, conflict or handover on one phase does not change the gates or the timing of the others.
- R10: A gate that is on goes low at the very next clock edge once its side is no longer the sole request, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_a | input | 1 | First gate enable, active high |
| en_b | input | 1 | Second gate enable, active high |
| fault | input | 1 | Forces all gates off while high |
| hi_cmd_n | input | 3 | High-side requests for phases A..C (bit 0 = A), active low |
| lo_cmd | input | 3 | Low-side requests for phases A..C (bit 0 = A), active high |
| cfg_we | input | 1 | Deadtime code write strobe |
| cfg_data | input | 8 | Deadtime code to be written |
| gate_hi | output | 3 | High-side gate enables, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gate enables, bit 0 = phase A |

## Verification
Two functions can fall in the same cycle: a write of a new deadtime code, and a phase counter that is just reaching or crossing the gap it compares against. An enable drop or fault can also coincide with a side handover. The random phase provokes both cases by writing small codes at random times while all three phases toggle their requests, and by pulsing the enables and the fault on top of live handovers. A behavioural model decides, on every clock, which code was in force at each edge and which request each phase saw, and the registered gates are compared against it in every cycle.

// File: rtl/tpg_pkg.sv
// Package tpg_pkg
// Shared decode for the three-phase deadtime controller. Turns the
// mixed-polarity command pair of one phase into an exclusive request.
// Assumes the commands are already synchronous to the system clock.
package tpg_pkg;

    typedef struct packed {
        logic want_hi;
        logic want_lo;
    } leg_want_t;

    // Exclusive request: a side is wanted only when it is the sole request.
    function automatic leg_want_t decode_cmd(input logic hi_n, input logic lo);
        leg_want_t w;
        w.want_hi = ~hi_n & ~lo;
        w.want_lo = lo & hi_n;
        return w;
    endfunction

endpackage

// File: rtl/tpg_dt_reg.sv
// Module tpg_dt_reg
// Holds the deadtime code and presents the gap as a counter limit
// (D-1, where D = (code+1)*STEP_CYC cycles). Reset loads the largest
// code. A write takes effect on the cycle after its edge.
// Assumes STEP_CYC >= 1 and that DT_W is wide enough for the largest D.
module tpg_dt_reg #(
    parameter int CODE_W   = 8,
    parameter int STEP_CYC = 2,
    parameter int DT_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_data,
    output logic [DT_W-1:0]   dt_last
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] code_q;

    // Code register: loaded on a write, set to the maximum by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_MAX;
        end else if (cfg_we) begin
            code_q <= cfg_data;
        end
    end

    // Counter limit: the gap in cycles, minus one.
    always_comb begin
        dt_last = ((DT_W'(code_q) + DT_W'(1)) * DT_W'(STEP_CYC)) - DT_W'(1);
    end

endmodule

// File: rtl/tpg_phase_leg.sv
// Module tpg_phase_leg
// One half-bridge leg. It keeps a gate on while its side remains the
// sole request and drops it at once otherwise. It counts cycles with
// both gates off and lets the requested side on only after dt_last+1
// such cycles. When allow is low, both gates are forced off and the
// count restarts.
// Assumes want_hi and want_lo are never high together.
module tpg_phase_leg #(
    parameter int DT_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            allow,
    input  logic            want_hi,
    input  logic            want_lo,
    input  logic [DT_W-1:0] dt_last,
    output logic            gate_hi,
    output logic            gate_lo
);
    logic [DT_W-1:0] idle_q;
    logic            hi_q;
    logic            lo_q;
    logic            gap_done;

    // Gap is complete once the idle count has reached the limit.
    always_comb begin
        gap_done = (idle_q >= dt_last);
    end

    // Gate state and idle counter of this leg.
    always_ff @(posedge clk) begin
        if (!rst_n || !allow) begin
            hi_q   <= 1'b0;
            lo_q   <= 1'b0;
            idle_q <= '0;
        end else if (hi_q || lo_q) begin
            hi_q   <= hi_q & want_hi;
            lo_q   <= lo_q & want_lo;
            idle_q <= '0;
        end else if (gap_done) begin
            hi_q   <= want_hi;
            lo_q   <= want_lo;
            idle_q <= idle_q;
        end else begin
            idle_q <= idle_q + DT_W'(1);
        end
    end

    assign gate_hi = hi_q;
    assign gate_lo = lo_q;

endmodule

// File: rtl/tpg_deadtime_ctrl.sv
// Module tpg_deadtime_ctrl (top)
// Three-phase gate controller with programmable deadtime. It decodes
// the mixed-polarity commands of each phase, ANDs the two enables with
// the inverted fault, and drives one leg instance per phase from a
// shared deadtime code register.
// Assumes all inputs are synchronous to clk; the reset is synchronous
// and active low.
module tpg_deadtime_ctrl #(
    parameter int PHASES   = 3,
    parameter int CODE_W   = 8,
    parameter int STEP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a,
    input  logic              en_b,
    input  logic              fault,
    input  logic [PHASES-1:0] hi_cmd_n,
    input  logic [PHASES-1:0] lo_cmd,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_data,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo
);
    import tpg_pkg::*;

    localparam int DT_MAX = (2 ** CODE_W) * STEP_CYC;
    localparam int DT_W   = $clog2(DT_MAX) + 1;

    logic            allow;
    logic [DT_W-1:0] dt_last;

    // Global gate permission: both enables high and no fault.
    always_comb begin
        allow = en_a & en_b & ~fault;
    end

    tpg_dt_reg #(
        .CODE_W  (CODE_W),
        .STEP_CYC(STEP_CYC),
        .DT_W    (DT_W)
    ) u_dt_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_data(cfg_data),
        .dt_last (dt_last)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        leg_want_t want;

        // Exclusive request of this phase.
        always_comb begin
            want = decode_cmd(hi_cmd_n[p], lo_cmd[p]);
        end

        tpg_phase_leg #(
            .DT_W(DT_W)
        ) u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .allow  (allow),
            .want_hi(want.want_hi),
            .want_lo(want.want_lo),
            .dt_last(dt_last),
            .gate_hi(gate_hi[p]),
            .gate_lo(gate_lo[p])
        );
    end

endmodule

// File: rtl/tpg_deadtime_chk.sv
// Module tpg_deadtime_chk
// Port-level checker for tpg_deadtime_ctrl, attached by bind below.
// Assumes the same clock and synchronous active-low reset as the top.
module tpg_deadtime_chk #(
    parameter int PHASES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_a,
    input logic              en_b,
    input logic              fault,
    input logic [PHASES-1:0] hi_cmd_n,
    input logic [PHASES-1:0] lo_cmd,
    input logic [PHASES-1:0] gate_hi,
    input logic [PHASES-1:0] gate_lo
);
    // R8
    reset_off_chk: assert property (@(posedge clk)
        !rst_n |=> (gate_hi == '0 && gate_lo == '0));

    // R3
    enable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_a && en_b) |=> (gate_hi == '0 && gate_lo == '0));

    // R4
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (gate_hi == '0 && gate_lo == '0));

    for (genvar p = 0; p < PHASES; p++) begin : g_chk
        // R5
        shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi[p] && gate_lo[p]));

        // R2
        conflict_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!hi_cmd_n[p] && lo_cmd[p]) |=> (!gate_hi[p] && !gate_lo[p]));

        // R1
        hi_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[p]) |-> $past(!hi_cmd_n[p] && !lo_cmd[p]));

        // R1
        lo_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[p]) |-> $past(lo_cmd[p] && hi_cmd_n[p]));

        // R6
        hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate_hi[p]) |=> !gate_lo[p]);

        // R6
        lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate_lo[p]) |=> !gate_hi[p]);

        // R10
        hi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_hi[p] && hi_cmd_n[p]) |=> !gate_hi[p]);
    end

endmodule

bind tpg_deadtime_ctrl tpg_deadtime_chk #(.PHASES(PHASES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_a    (en_a),
    .en_b    (en_b),
    .fault   (fault),
    .hi_cmd_n(hi_cmd_n),
    .lo_cmd  (lo_cmd),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo)
);

// File: tb/tpg_deadtime_ctrl_bench.sv
module tpg_deadtime_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NPH        = 3;
    localparam int STEP       = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           en_a = 1'b0;
    logic           en_b = 1'b0;
    logic           fault = 1'b0;
    logic [NPH-1:0] hi_cmd_n = '1;
    logic [NPH-1:0] lo_cmd = '0;
    logic           cfg_we = 1'b0;
    logic [7:0]     cfg_data = '0;
    logic [NPH-1:0] gate_hi;
    logic [NPH-1:0] gate_lo;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tpg_deadtime_ctrl #(.PHASES(NPH), .CODE_W(8), .STEP_CYC(STEP)) u_tpg_deadtime_ctrl (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .en_b(en_b), .fault(fault),
        .hi_cmd_n(hi_cmd_n), .lo_cmd(lo_cmd), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    // Behavioural reference: per-phase off-time counts and the code in force.
    int m_code = 255;
    bit m_hi[NPH];
    bit m_lo[NPH];
    int m_off[NPH];

    always @(posedge clk) begin : model
        int gap;
        bit wh;
        bit wl;
        if (!rst_n) begin
            m_code = 255;
            for (int p = 0; p < NPH; p++) begin
                m_hi[p] = 0; m_lo[p] = 0; m_off[p] = 0;
            end
        end else begin
            gap = (m_code + 1) * STEP;
            for (int p = 0; p < NPH; p++) begin
                wh = !hi_cmd_n[p] && !lo_cmd[p];
                wl = lo_cmd[p] && hi_cmd_n[p];
                if (!(en_a && en_b) || fault) begin
                    m_hi[p] = 0; m_lo[p] = 0; m_off[p] = 0;
                end else if (m_hi[p] || m_lo[p]) begin
                    m_hi[p] = m_hi[p] && wh;
                    m_lo[p] = m_lo[p] && wl;
                    m_off[p] = 0;
                end else if (m_off[p] + 1 >= gap) begin
                    m_hi[p] = wh; m_lo[p] = wl;
                end else begin
                    m_off[p] = m_off[p] + 1;
                end
            end
            if (cfg_we) m_code = int'(cfg_data);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle against the model (R5, R6, R9 and the rest).
    always @(negedge clk) begin
        if (!done) begin
            for (int p = 0; p < NPH; p++) begin
                checks++;
                if (gate_hi[p] !== m_hi[p] || gate_lo[p] !== m_lo[p]) begin
                    errors++;
                    $display("FAIL %s phase %0d actual=%b%b expected=%b%b at %0t",
                             (gate_hi[p] && gate_lo[p]) ? "R5" : "R6", p,
                             gate_hi[p], gate_lo[p], m_hi[p], m_lo[p], $time);
                end
            end
        end
    end

    task automatic wait_rise(input int p, input bit hi_side, input int exp_n, input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(hi_side ? gate_hi[p] : gate_lo[p]) && n < 2000);
        check(n == exp_n, tag, n, exp_n);
    endtask

    task automatic write_code(input int code);
        cfg_we = 1'b1; cfg_data = 8'(code);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        check(gate_hi == 0 && gate_lo == 0, "R8", int'({gate_hi, gate_lo}), 0);

        // R8 default code 255 gives 512 cycles
        en_a = 1; en_b = 1; hi_cmd_n = 3'b110; rst_n = 1;
        wait_rise(0, 1, 512, "R8");
        // R1 active-low high-side command
        check(gate_hi[0] && !gate_lo[0], "R1", int'({gate_hi[0], gate_lo[0]}), 2);

        // R7 code 3 -> D = 8
        write_code(3);
        hi_cmd_n[0] = 1; lo_cmd[0] = 1;
        @(negedge clk);
        // R10 immediate release
        check(!gate_hi[0] && !gate_lo[0], "R10", int'({gate_hi[0], gate_lo[0]}), 0);
        // R6 / R7: D+1 = 9 cycles after the change, 1 already spent
        wait_rise(0, 0, 8, "R7");
        // R1 active-high low-side command
        check(gate_lo[0] && !gate_hi[0], "R1", int'({gate_hi[0], gate_lo[0]}), 1);

        // R9: idle phase 1 responds at once, phase 0 untouched
        hi_cmd_n[1] = 0;
        wait_rise(1, 1, 1, "R9");
        check(gate_lo[0] == 1, "R9", int'(gate_lo[0]), 1);

        // R2 conflict on phase 2
        hi_cmd_n[2] = 0; lo_cmd[2] = 1;
        repeat (12) @(negedge clk);
        check(!gate_hi[2] && !gate_lo[2], "R2", int'({gate_hi[2], gate_lo[2]}), 0);
        hi_cmd_n[2] = 1;
        wait_rise(2, 0, 1, "R2");

        // R3 enable drop, then counters restart
        en_b = 0;
        @(negedge clk);
        check(gate_hi == 0 && gate_lo == 0, "R3", int'({gate_hi, gate_lo}), 0);
        en_b = 1;
        wait_rise(0, 0, 8, "R3");

        // R4 fault override
        fault = 1;
        @(negedge clk);
        check(gate_hi == 0 && gate_lo == 0, "R4", int'({gate_hi, gate_lo}), 0);
        repeat (3) @(negedge clk);
        check(gate_hi == 0 && gate_lo == 0, "R4", int'({gate_hi, gate_lo}), 0);
        fault = 0;
        repeat (10) @(negedge clk);

        // R6 shortest gap: code 0 -> D = 2, handover takes 3 cycles
        write_code(0);
        hi_cmd_n[1] = 1; lo_cmd[1] = 1;
        wait_rise(1, 0, 3, "R6");

        // Random stretch, compared each cycle against the model
        for (int i = 0; i < 4000; i++) begin
            hi_cmd_n = ($urandom_range(0, 3) == 0) ? NPH'($urandom) : hi_cmd_n;
            lo_cmd   = ($urandom_range(0, 3) == 0) ? NPH'($urandom) : lo_cmd;
            en_a     = ($urandom_range(0, 60) != 0);
            en_b     = ($urandom_range(0, 60) != 0);
            fault    = ($urandom_range(0, 80) == 0);
            cfg_we   = ($urandom_range(0, 40) == 0);
            cfg_data = 8'($urandom_range(0, 7));
            @(negedge clk);
        end
        cfg_we = 0;
        finish_run();
    end

endmodule